// File: doc/BRIEF.md
# Flash Block Erase Controller

This controller lets an on-chip processor erase one block of program flash through a small register window. Software loads a 22-bit byte pointer and sets the mode bits in a control register. It then writes two key bytes, in order, to a write-only key register. A control write with the start bit set ends the sequence. The controller checks the mode bits and the unlock state together with that start write. When both are valid, it sends a single erase strobe and a 16-bit block index to the flash array.

An erase always covers a 64-byte (32-word) block, so the low six pointer bits play no part. While the erase runs, a stall output holds the processor for a fixed number of cycles, counted by an internal timer. The cycle count is a parameter: about 2 ms of clock cycles in silicon, and a short value in simulation. A start attempt with bad mode bits raises an error flag. A broken unlock sequence leaves no trace.

Register map (3-bit address, byte data): 0 = pointer bits [7:0], 1 = pointer bits [15:8], 2 = pointer bits [21:16] in data bits [5:0], 3 = control, 4 = key. Control bits: [0] start/busy, [1] write enable, [2] erase select, [3] configuration-space select, [4] program-flash select, [5] error.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset, every register reads zero, and the stall output, the erase strobe and the block index are zero.
- R2: A valid start makes the erase strobe high for exactly one cycle, in the cycle after the start write. The block index then equals pointer bits [21:6], whatever pointer bits [5:0] hold.
- R3: The stall output rises together with the strobe and stays high for exactly ERASE_CYCLES cycles.
- R4: Control bit 0 reads 1 while the erase runs, and writing 0 to it has no effect. It reads 0 once the stall ends.
- R5: A start write is valid only if bit 4 = 1, bit 3 = 0, bit 1 = 1 and bit 2 = 1 in that same write. Otherwise the write sets the error flag (control bit 5) and no erase is issued.
- R6: The erase is armed only by a write of 0x55 to the key register, then a write of 0xAA, then the start write. A wrong key value, any other register write in between, or a start before both keys issues no erase and leaves the error flag unchanged.
- R7: The unlock state is cleared after every start attempt, so a second start without new keys issues no erase.
- R8: The key register always reads 0x00.
- R9: Pointer writes during an erase do not change the block index of that erase.
- R10: A control write with bit 5 = 0 clears the error flag, but a failed start in that same write leaves it set. A write with bit 5 = 1 keeps the flag as it is.
- R11: A complete unlock and start while an erase runs issues no strobe and does not extend the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cpu_stall | output | 1 | Processor hold while an erase runs |
| fl_erase | output | 1 | One-cycle block erase command to the flash array |
| fl_block | output | 16 | Block index of the current erase |

## Verification
The mode check and the error-flag clear both act on the control write that carries the start bit. The bench therefore makes a complete unlock followed by a start write that clears bit 5 while also clearing the write-enable bit. It then expects the error flag to read 1, with no strobe. A second collision places a full unlock and start, plus pointer writes, inside a running erase. This is judged by the absence of a second strobe, an unchanged block index, and a total stall length of exactly ERASE_CYCLES cycles.

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int ERASE_CYCLES = 100000,
  parameter int PTR_W        = 22,
  parameter int BLK_LSB      = 6,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        cpu_stall,
  output logic        fl_erase,
  output logic [15:0] fl_block
);
  localparam int HI_W  = PTR_W - 16;
  localparam int BLK_W = PTR_W - BLK_LSB;
  localparam int CNT_W = $clog2(ERASE_CYCLES);

  typedef enum logic [1:0] {UL_IDLE, UL_GOT_A, UL_ARMED} unlock_t;

  logic [PTR_W-1:0] ptr;
  logic             busy, err;
  logic             wen, ers_sel, cfg_sel, fls_sel;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk;
  unlock_t          ustate;

  wire wr_ptr   = reg_wr && (reg_addr <= 3'd2);
  wire wr_ctrl  = reg_wr && (reg_addr == 3'd3);
  wire wr_key   = reg_wr && (reg_addr == 3'd4);
  wire start_rq = wr_ctrl && reg_wdata[0] && !busy;
  wire mode_ok  = reg_wdata[4] && !reg_wdata[3] && reg_wdata[1] && reg_wdata[2];
  wire go       = start_rq && mode_ok && (ustate == UL_ARMED);
  wire bad      = start_rq && !mode_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_ptr) begin
      case (reg_addr)
        3'd0:    ptr[7:0]        <= reg_wdata;
        3'd1:    ptr[15:8]       <= reg_wdata;
        default: ptr[PTR_W-1:16] <= reg_wdata[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {wen, ers_sel, cfg_sel, fls_sel, err} <= '0;
    end else if (wr_ctrl) begin
      wen     <= reg_wdata[1];
      ers_sel <= reg_wdata[2];
      cfg_sel <= reg_wdata[3];
      fls_sel <= reg_wdata[4];
      err     <= bad || (err && reg_wdata[5]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ustate <= UL_IDLE;
    else if (wr_key) begin
      if (reg_wdata == KEY_A)
        ustate <= UL_GOT_A;
      else if (reg_wdata == KEY_B && ustate == UL_GOT_A)
        ustate <= UL_ARMED;
      else
        ustate <= UL_IDLE;
    end else if (reg_wr)
      ustate <= UL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      blk      <= '0;
      fl_erase <= 1'b0;
    end else begin
      fl_erase <= go;
      if (go) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(ERASE_CYCLES - 1);
        blk  <= ptr[PTR_W-1:BLK_LSB];
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign cpu_stall = busy;
  assign fl_block  = blk;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ptr[7:0];
      3'd1:    reg_rdata = ptr[15:8];
      3'd2:    reg_rdata = {{(8-HI_W){1'b0}}, ptr[PTR_W-1:16]};
      3'd3:    reg_rdata = {2'b00, err, fls_sel, cfg_sel, ers_sel, wen, busy};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
  parameter int ERASE_CYCLES = 100000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic        cpu_stall,
  input logic        fl_erase,
  input logic [15:0] fl_block
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n)         run <= 0;
    else if (cpu_stall) run <= run + 1;
    else                run <= 0;
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |=> !fl_erase);

  assert_strobe_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> $past(reg_wr && reg_addr == 3'd3 && reg_wdata[0]));

  assert_stall_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> fl_erase);

  assert_stall_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> run == ERASE_CYCLES);

  assert_stall_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> run < ERASE_CYCLES);

  assert_block_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && !fl_erase) |-> $stable(fl_block));

  assert_busy_reads_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && reg_addr == 3'd3) |-> reg_rdata[0]);

  assert_key_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4) |-> reg_rdata == 8'h00);
endmodule

bind flash_erase_ctl flash_erase_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
  .fl_erase(fl_erase), .fl_block(fl_block)
);

// File: tb/sim_flash_erase_ctl.sv
`timescale 1ns/1ps
module sim_flash_erase_ctl;
  localparam int N = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_stall, fl_erase;
  logic [15:0] fl_block;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_erase_ctl #(.ERASE_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
    .fl_erase(fl_erase), .fl_block(fl_block)
  );

  // key1, key2, control, expect erase, expect error
  localparam logic [25:0] VEC [11] = '{
    {8'h55, 8'hAA, 8'h17, 1'b1, 1'b0},
    {8'hAA, 8'h55, 8'h17, 1'b0, 1'b0},
    {8'h55, 8'h55, 8'h17, 1'b0, 1'b0},
    {8'h55, 8'hAA, 8'h15, 1'b0, 1'b1},
    {8'h55, 8'hAA, 8'h13, 1'b0, 1'b1},
    {8'h55, 8'hAA, 8'h1F, 1'b0, 1'b1},
    {8'h55, 8'hAA, 8'h07, 1'b0, 1'b1},
    {8'h12, 8'hAA, 8'h17, 1'b0, 1'b0},
    {8'h55, 8'hAA, 8'h16, 1'b0, 1'b0},
    {8'hAA, 8'hAA, 8'h17, 1'b0, 1'b0},
    {8'h55, 8'hAA, 8'h37, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    wr(3'd0, p[7:0]); wr(3'd1, p[15:8]); wr(3'd2, {2'b00, p[21:16]});
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [21:0] p;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 reg", d, 0); end
    chk("R1 stall", cpu_stall, 0);
    chk("R1 strobe", fl_erase, 0);
    chk("R1 block", fl_block, 0);

    // vector table: R2 R3 R5 R6
    for (int i = 0; i < 11; i++) begin
      p = {6'(i + 33), 8'(8'h5A + i * 17), 8'hFF};
      set_ptr(p);
      wr(3'd3, 8'h00);
      wr(3'd4, VEC[i][25:18]);
      wr(3'd4, VEC[i][17:10]);
      wr(3'd3, VEC[i][9:2]);
      chk("R2/R5/R6 strobe", fl_erase, VEC[i][1]);
      if (VEC[i][1]) chk("R2 block", fl_block, p[21:6]);
      rd(3'd3, d);
      chk("R5/R6 error flag", d[5], VEC[i][0]);
      if (VEC[i][1]) begin
        count_stall(n);
        chk("R3 stall length", n, N);
      end
      @(negedge clk);
      chk("R2 single strobe", fl_erase, 0);
    end

    // R6 intervening write between keys
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h55); wr(3'd0, 8'h11); wr(3'd4, 8'hAA); wr(3'd3, 8'h17);
    chk("R6 intervening write", fl_erase, 0);
    rd(3'd3, d); chk("R6 no error", d[5], 0);
    // R6 start after first key only
    wr(3'd4, 8'h55); wr(3'd3, 8'h17);
    chk("R6 early start", fl_erase, 0);

    // R8 key reads zero
    wr(3'd4, 8'h55);
    rd(3'd4, d); chk("R8 key read", d, 0);

    // R4 R9 R11 busy behaviour
    p = 22'h3ABC80;
    set_ptr(p);
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd3, 8'h17);
    chk("R2 strobe", fl_erase, 1);
    chk("R2 block", fl_block, 16'hEAF2);
    rd(3'd3, d); chk("R4 busy reads 1", d[0], 1);
    wr(3'd3, 8'h16);
    rd(3'd3, d); chk("R4 clear ignored", d[0], 1);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    chk("R9 block held", fl_block, 16'hEAF2);
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd3, 8'h17);
    chk("R11 no restrobe", fl_erase, 0);
    count_stall(n);
    chk("R11 stall not extended", n, N - 6);
    rd(3'd3, d); chk("R4 cleared at end", d[0], 0);
    chk("R9 block after", fl_block, 16'hEAF2);

    // R7 start again without new keys
    set_ptr(p);
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd3, 8'h17);
    chk("R7 first start", fl_erase, 1);
    count_stall(n);
    wr(3'd3, 8'h17);
    chk("R7 no rekey", fl_erase, 0);

    // R10 error flag set/clear collision
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd3, 8'h15);
    rd(3'd3, d); chk("R5 error set", d[5], 1);
    wr(3'd3, 8'h20);
    rd(3'd3, d); chk("R10 keep with 1", d[5], 1);
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd3, 8'h05);
    chk("R10 no strobe", fl_erase, 0);
    rd(3'd3, d); chk("R10 set wins", d[5], 1);
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk("R10 cleared", d[5], 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule